// File: doc/BRIEF.md
# Two-Tier Fixed-Order Channel Arbiter

This block chooses which of several DMA channels gets the next arbitration slot. Every channel drives one request line and has a one-bit level, default or elevated. The levels sit in a register that software changes through two write ports. A write to the raise port sets every level whose data bit is 1. A write to the lower port clears every level whose data bit is 1. Data bits that are 0 leave their channel's level as it was.

The transfer engine pulses `arbStrobe` when the serviced channel finishes. In single-transfer mode that is after every beat; in burst mode it is after a burst of 2^R beats. On that edge the arbiter registers a new winner. Any requesting elevated channel beats every requesting default channel, and within a tier the lowest channel index wins. The winner is presented as a one-hot grant, an encoded index and a valid flag, and these hold until the next strobe.

Top module: `tierArbiter`

## Requirements
- R1: While reset is applied and after it is released, every channel level is default (0), `grantValid` is 0, `grantOneHot` is all zeros and `grantIdx` is 0.
- R2: On a clock edge with `raiseWr` high, every channel whose bit in `raiseData` is 1 becomes elevated (level bit 1). Channels whose bit is 0 keep their level.
- R3: On a clock edge with `lowerWr` high, every channel whose bit in `lowerData` is 1 returns to default (level bit 0). Channels whose bit is 0 keep their level.
- R4: When the same channel is raised and lowered on the same edge, it ends up elevated.
- R5: At an arbitration edge, if any requesting channel is elevated, the grant goes to an elevated channel, whatever the default channels request.
- R6: Within the tier that wins, the requesting channel with the lowest index receives the grant.
- R7: `grantOneHot`, `grantIdx` and `grantValid` change only on a clock edge where `arbStrobe` is high, and show the new result in the following cycle. Between strobes they hold, even when requests change.
- R8: If no channel requests at an arbitration edge, `grantValid` goes to 0, `grantOneHot` to all zeros and `grantIdx` to 0.
- R9: A level write on the same edge as an arbitration uses the levels from before that write. The new levels take effect from the next arbitration.
- R10: While `grantValid` is 1, `grantOneHot` has exactly one bit set, and that bit is at position `grantIdx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqVec | input | NCH | Request line per channel, bit i is channel i |
| arbStrobe | input | 1 | End of beat or burst; re-arbitrate on this edge |
| raiseWr | input | 1 | Write strobe for the raise (set) port |
| raiseData | input | NCH | Write-1 mask that elevates channels |
| lowerWr | input | 1 | Write strobe for the lower (clear) port |
| lowerData | input | NCH | Write-1 mask that returns channels to default |
| prioLevel | output | NCH | Current level per channel, 1 means elevated |
| grantOneHot | output | NCH | Registered one-hot grant |
| grantIdx | output | $clog2(NCH) | Registered index of the granted channel |
| grantValid | output | 1 | Registered flag: the grant names a channel |

## Verification
Two functions can meet in one cycle. A level write can land on the same edge as an arbitration, and a raise can hit the same channel as a lower. The bench drives a raise together with `arbStrobe` while two channels request. The grant that follows must reflect the old levels, and a second strobe must then reflect the new ones. For the collision, the bench drives a raise and a lower on one bit, and every table vector loads its levels as a full lower plus a raise. `prioLevel` must then read back as exactly the raised mask.

// File: rtl/arbPkg.sv
package arbPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadGrant;
    logic setEn;
    logic clrEn;
  } arbCtrl_t;
endpackage

// File: rtl/arbControl.sv
module arbControl
  import arbPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     arbStrobe,
  input  logic     raiseWr,
  input  logic     lowerWr,
  output arbCtrl_t ctrl
);
  always_comb begin
    ctrl           = '0;
    ctrl.loadGrant = arbStrobe;
    ctrl.setEn     = raiseWr;
    ctrl.clrEn     = lowerWr;
  end

  // the datapath may only see known strobes once out of reset
  a_r7_known_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown(ctrl))
    else $error("a_r7_known_strobe");
endmodule

// File: rtl/arbDatapath.sv
module arbDatapath
  import arbPkg::*;
#(
  parameter int NCH  = 16,
  parameter int IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  arbCtrl_t        ctrl,
  input  logic [NCH-1:0]  reqVec,
  input  logic [NCH-1:0]  raiseData,
  input  logic [NCH-1:0]  lowerData,
  output logic [NCH-1:0]  prioLevel,
  output logic [NCH-1:0]  grantOneHot,
  output logic [IDXW-1:0] grantIdx,
  output logic            grantValid
);
  logic [NCH-1:0]  prioQ, prioNext;
  logic [NCH-1:0]  hiReq, tierReq, pick;
  logic [NCH:0]    seen;
  logic [IDXW-1:0] winIdx;
  logic [NCH-1:0]  grantQ;
  logic [IDXW-1:0] idxQ;
  logic            validQ;

  // level register: clear first, then set, so set wins (R4)
  always_comb begin
    prioNext = prioQ;
    if (ctrl.clrEn) prioNext = prioNext & ~lowerData;
    if (ctrl.setEn) prioNext = prioNext | raiseData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prioQ <= '0;
    else       prioQ <= prioNext;
  end

  // tier select: elevated requesters mask out default ones
  assign hiReq   = reqVec & prioQ;
  assign tierReq = (|hiReq) ? hiReq : reqVec;

  // lowest index wins inside the tier
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < NCH; i++) begin : g_scan
    assign pick[i]   = tierReq[i] & ~seen[i];
    assign seen[i+1] = seen[i] | tierReq[i];
  end

  always_comb begin
    winIdx = '0;
    for (int i = 0; i < NCH; i++)
      if (pick[i]) winIdx = IDXW'(i);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantQ <= '0;
      idxQ   <= '0;
      validQ <= 1'b0;
    end else if (ctrl.loadGrant) begin
      grantQ <= pick;
      idxQ   <= winIdx;
      validQ <= |reqVec;
    end
  end

  assign prioLevel   = prioQ;
  assign grantOneHot = grantQ;
  assign grantIdx    = idxQ;
  assign grantValid  = validQ;

  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.loadGrant |=> ($stable(grantQ) && $stable(idxQ) && $stable(validQ)))
    else $error("a_r7_hold");

  a_r10_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantQ) && (validQ == (grantQ != '0)) && (!validQ || grantQ[idxQ]))
    else $error("a_r10_onehot");

  a_r8_idle: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadGrant && reqVec == '0) |=> (!validQ && idxQ == '0))
    else $error("a_r8_idle");

  a_r5_tier: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadGrant && (reqVec & prioQ) != '0) |=> ((grantQ & $past(prioQ)) != '0))
    else $error("a_r5_tier");

  a_r2_set: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.setEn |=> ((prioQ & $past(raiseData)) == $past(raiseData)))
    else $error("a_r2_set");

  a_r3_clr: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.clrEn && !ctrl.setEn) |=> ((prioQ & $past(lowerData)) == '0))
    else $error("a_r3_clr");
endmodule

// File: rtl/tierArbiter.sv
module tierArbiter
  import arbPkg::*;
#(
  parameter int NCH  = 16,
  parameter int IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NCH-1:0]  reqVec,
  input  logic            arbStrobe,
  input  logic            raiseWr,
  input  logic [NCH-1:0]  raiseData,
  input  logic            lowerWr,
  input  logic [NCH-1:0]  lowerData,
  output logic [NCH-1:0]  prioLevel,
  output logic [NCH-1:0]  grantOneHot,
  output logic [IDXW-1:0] grantIdx,
  output logic            grantValid
);
  arbCtrl_t ctrl;

  arbControl i_ctrl (
    .clk(clk), .rstN(rstN), .arbStrobe(arbStrobe),
    .raiseWr(raiseWr), .lowerWr(lowerWr), .ctrl(ctrl)
  );

  arbDatapath #(.NCH(NCH), .IDXW(IDXW)) i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .reqVec(reqVec),
    .raiseData(raiseData), .lowerData(lowerData),
    .prioLevel(prioLevel), .grantOneHot(grantOneHot),
    .grantIdx(grantIdx), .grantValid(grantValid)
  );
endmodule

// File: tb/test_tierArbiter.sv
`timescale 1ns/1ps
module test_tierArbiter;
  localparam int NCH = 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NCH-1:0]  reqVec = '0;
  logic            arbStrobe = 1'b0;
  logic            raiseWr = 1'b0;
  logic [NCH-1:0]  raiseData = '0;
  logic            lowerWr = 1'b0;
  logic [NCH-1:0]  lowerData = '0;
  logic [NCH-1:0]  prioLevel, grantOneHot;
  logic [3:0]      grantIdx;
  logic            grantValid;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tierArbiter #(.NCH(NCH)) i_tierArbiter (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .arbStrobe(arbStrobe),
    .raiseWr(raiseWr), .raiseData(raiseData), .lowerWr(lowerWr),
    .lowerData(lowerData), .prioLevel(prioLevel), .grantOneHot(grantOneHot),
    .grantIdx(grantIdx), .grantValid(grantValid)
  );

  // {levels, requests, expected index, expected valid}
  localparam logic [47:0] VEC [8] = '{
    {16'h0000, 16'h0000, 8'd0,  8'd0},  // R8 idle
    {16'h0000, 16'h8001, 8'd0,  8'd1},  // R6 default tier
    {16'h0000, 16'h00F0, 8'd4,  8'd1},  // R6
    {16'h8000, 16'h8001, 8'd15, 8'd1},  // R5 high beats lower index
    {16'h0A00, 16'h0E07, 8'd9,  8'd1},  // R5 R6
    {16'hFFFF, 16'h0300, 8'd8,  8'd1},  // R6 all high
    {16'h0001, 16'h0002, 8'd1,  8'd1},  // R5 idle high channel
    {16'h1000, 16'hF000, 8'd12, 8'd1}   // R5
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clearStrobes();
    arbStrobe = 1'b0; raiseWr = 1'b0; lowerWr = 1'b0;
  endtask

  task automatic checkGrant(string tag, int idx, bit valid);
    check({tag, " valid"}, 32'(grantValid), 32'(valid));
    check({tag, " idx"}, 32'(grantIdx), valid ? 32'(idx) : 32'd0);
    check({tag, " onehot"}, 32'(grantOneHot), valid ? (32'd1 << idx) : 32'd0);
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 level in reset", 32'(prioLevel), 0);
    checkGrant("R1 grant in reset", 0, 0);
    rstN = 1'b1;
    tick();
    check("R1 level", 32'(prioLevel), 0);
    checkGrant("R1 grant", 0, 0);

    // table walk: load levels via full lower + raise (R4), then arbitrate
    for (int v = 0; v < 8; v++) begin
      lowerWr = 1'b1; lowerData = '1;
      raiseWr = 1'b1; raiseData = VEC[v][47:32];
      tick();
      clearStrobes();
      check("R4 load levels", 32'(prioLevel), 32'(VEC[v][47:32]));
      reqVec = VEC[v][31:16]; arbStrobe = 1'b1;
      tick();
      clearStrobes();
      checkGrant("R5 R6 R8 R10 vector", int'(VEC[v][15:8]), VEC[v][0]);
    end

    // R2 / R3: zero bits untouched
    lowerWr = 1'b1; lowerData = '1; tick(); clearStrobes();
    raiseWr = 1'b1; raiseData = 16'h00A5; tick(); clearStrobes();
    check("R2 raise", 32'(prioLevel), 32'h00A5);
    raiseWr = 1'b1; raiseData = 16'h0100; tick(); clearStrobes();
    check("R2 zero bits keep", 32'(prioLevel), 32'h01A5);
    lowerWr = 1'b1; lowerData = 16'h0005; tick(); clearStrobes();
    check("R3 lower", 32'(prioLevel), 32'h01A0);
    // R4 same bit in both writes
    raiseWr = 1'b1; raiseData = 16'h0002;
    lowerWr = 1'b1; lowerData = 16'h0002; tick(); clearStrobes();
    check("R4 raise wins", 32'(prioLevel), 32'h01A2);

    // R7: hold between strobes
    reqVec = 16'h0010; arbStrobe = 1'b1; tick(); clearStrobes();
    checkGrant("R7 first", 4, 1);      // bit4 default, only requester
    reqVec = 16'h0000; tick();
    checkGrant("R7 hold no req", 4, 1);
    reqVec = 16'h0102; tick();
    checkGrant("R7 hold new req", 4, 1);
    arbStrobe = 1'b1; tick(); clearStrobes();
    checkGrant("R7 rearbitrate", 1, 1);  // bits 1 and 8 both high -> 1

    // R9: level write on the arbitration edge
    lowerWr = 1'b1; lowerData = '1; tick(); clearStrobes();
    reqVec = 16'h0003; raiseWr = 1'b1; raiseData = 16'h0002; arbStrobe = 1'b1;
    tick(); clearStrobes();
    checkGrant("R9 old levels", 0, 1);
    arbStrobe = 1'b1; tick(); clearStrobes();
    checkGrant("R9 new levels", 1, 1);

    // R8 after an active grant
    reqVec = '0; arbStrobe = 1'b1; tick(); clearStrobes();
    checkGrant("R8 drop", 0, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule